// File: doc/BRIEF.md
# PCM Time-Slot Serial Port

This block carries one byte-wide PCM sample per frame in each direction over a serial PCM bus. The whole block runs on a fast system clock and samples the bus bit clock as an ordinary input. The rising and falling edges of the bit clock are found inside the block, so transmit bits are launched on one edge and receive bits are captured on the other. Each direction has its own frame-sync input, its own position counter and its own slot assignment. The two frames may therefore sit at any bit offset from each other.

The block has two timing modes. In the immediate mode, the frame-sync leading edge is itself the first bit of the only usable slot. In the offset mode, the frame-sync leading edge marks the frame start, and any of up to 64 byte slots can be picked. The transmit side drives serial data with a tri-state enable and an active-low enable for an external line driver. It takes its byte from an encoder through a load strobe at the start of the slot. In loopback, it instead returns the byte most recently received. The receive side hands each completed byte to a decoder with a one-cycle valid strobe. Rewriting a slot assignment, or powering the transmitter up, opens that path only after two further frame syncs.

Top module: `pcm_slot_port`

## Requirements
- R1: In an active transmit slot, `tx_oe` rises when the bit clock rise for bit 0 is seen and stays high for exactly 8 bit periods. `tx_data` shows the byte MSB first and changes only when a bit clock rising edge is seen.
- R2: Receive bits are sampled on bit clock falling edges, MSB first. After the falling edge of the eighth bit, `rx_byte` holds the byte and `rx_valid` pulses high for one clock.
- R3: When `delayed_mode` is 0, the slot starts on the first bit clock rise at which the frame sync is seen high after being low. Only slot number 0 transfers in this mode; a nonzero slot number gives no transfer.
- R4: When `delayed_mode` is 1, the bit clock rise that sees the frame-sync leading edge is not a data bit. Slot N starts 8·N+1 rises after it. A slot that lies beyond the next frame sync never transfers.
- R5: `cfg_wdata` bit 6 is the enable and bits 5:0 are the binary slot number. With the enable clear, `tx_oe` stays low and received bits produce no `rx_valid`. After reset both directions are disabled.
- R6: A write (`tx_cfg_wr` or `rx_cfg_wr`) stops that direction at once, even in the middle of a slot. The new assignment first transfers in the frame opened by the second frame-sync leading edge after the write.
- R7: `tx_drv_n` goes low together with `tx_oe` at the start of the slot. It returns high on the bit clock falling edge inside the eighth bit, so it covers 7.5 bit times.
- R8: While `power_up` is 0, `tx_oe` stays low. After `power_up` rises, nothing is sent until the frame opened by the second transmit frame-sync leading edge.
- R9: The transmit and receive position counters run from their own frame syncs, so the two frames may be skewed by any number of bit clocks.
- R10: With `loopback` set, the transmit slot sends the last byte held on `rx_byte` in place of `tx_byte`.
- R11: `tx_load` pulses high for one clock at the start of each transmitted slot. That is the moment `tx_byte` is captured for shifting out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk | input | 1 | PCM bus bit clock, sampled on clk |
| tx_fs | input | 1 | Transmit frame sync |
| rx_fs | input | 1 | Receive frame sync |
| rx_data | input | 1 | Serial receive data |
| delayed_mode | input | 1 | 1 = offset mode with slot selection, 0 = immediate mode |
| loopback | input | 1 | Send the last received byte in the transmit slot |
| power_up | input | 1 | Transmit power state, 1 = up |
| tx_cfg_wr | input | 1 | Write strobe for the transmit slot assignment |
| rx_cfg_wr | input | 1 | Write strobe for the receive slot assignment |
| cfg_wdata | input | 7 | Assignment word: bit 6 enable, bits 5:0 slot number |
| tx_byte | input | 8 | Byte from the encoder |
| tx_data | output | 1 | Serial transmit data, valid while tx_oe is high |
| tx_oe | output | 1 | Tri-state enable for tx_data |
| tx_drv_n | output | 1 | Active-low enable for an external line driver |
| tx_load | output | 1 | One-clock strobe: tx_byte taken |
| rx_byte | output | 8 | Last completed receive byte |
| rx_valid | output | 1 | One-clock strobe: rx_byte updated |

## Verification
On every clock, the assertions check the local timing rules:
- the driver enable never lasts outside the output enable;
- a load only happens with both enables asserted;
- transmit data and position counters move only on a bit clock rise;
- a receive byte appears only after a falling edge;
- a write or a power-down silences the transmitter on the next clock.

The frame-level properties are shown only by the bench's scenarios. These are:
- the two-frame activation delay after a write or power-up;
- the position of slot N in offset mode and its absence when the slot lies past the frame end;
- the rejection of nonzero slots in immediate mode;
- independent transmit and receive skew;
- the byte returned in loopback.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;

    // width of the binary slot number in an assignment word
    parameter int unsigned PCM_SLOT_W = 6;

    typedef struct packed {
        logic                  en;
        logic [PCM_SLOT_W-1:0] num;
    } slot_cfg_t;

endpackage

// File: rtl/pcm_slot_timer.sv
module pcm_slot_timer
    import pcm_slot_pkg::*;
#(
    parameter  int unsigned BYTE_W = 8,
    localparam int unsigned IDX_W  = $clog2(BYTE_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic             fs,
    input  logic             delayed,
    input  logic             wr,
    input  logic             gate,
    input  slot_cfg_t        wcfg,
    output logic             hit,
    output logic [IDX_W-1:0] idx,
    output logic             abort
);
    localparam int unsigned POS_W = PCM_SLOT_W + IDX_W + 1;
    localparam logic [POS_W-1:0] POS_IDLE = {1'b1, {(POS_W-1){1'b0}}};

    typedef struct packed {
        logic             fs_prev;
        logic [POS_W-1:0] pos;
        logic [1:0]       arm;
        slot_cfg_t        cfg;
    } tmr_st_t;

    tmr_st_t          s_d, s_q;
    logic             lead;
    logic             armed_now;
    logic [POS_W-1:0] cur;

    always_comb begin
        s_d   = s_q;
        lead  = rise & fs & ~s_q.fs_prev;
        abort = wr | ~gate;
        cur   = s_q.pos;
        if (lead) begin
            cur = delayed ? POS_IDLE : '0;
        end
        armed_now = ~abort & ((s_q.arm == 2'd2) | (lead & (s_q.arm == 2'd1)));
        hit = rise & armed_now & s_q.cfg.en & ~cur[POS_W-1]
            & (delayed | (s_q.cfg.num == '0))
            & (cur[POS_W-2:IDX_W] == s_q.cfg.num);
        idx = cur[IDX_W-1:0];
        if (rise) begin
            s_d.fs_prev = fs;
            if (lead & delayed) begin
                s_d.pos = '0;
            end else if (!cur[POS_W-1]) begin
                s_d.pos = cur + POS_W'(1);
            end else begin
                s_d.pos = POS_IDLE;
            end
        end
        if (abort) begin
            s_d.arm = 2'd0;
        end else if (lead && (s_q.arm != 2'd2)) begin
            s_d.arm = s_q.arm + 2'd1;
        end
        if (wr) begin
            s_d.cfg = wcfg;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.fs_prev <= 1'b0;
            s_q.pos     <= POS_IDLE;
            s_q.arm     <= 2'd0;
            s_q.cfg     <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R4: the frame position advances only on a seen bit clock rise
    a_r4_pos_moves_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(s_q.pos));

    // R6: a write clears the activation count
    a_r6_write_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (s_q.arm == 2'd0));

endmodule

// File: rtl/pcm_tx_path.sv
module pcm_tx_path #(
    parameter  int unsigned BYTE_W = 8,
    localparam int unsigned IDX_W  = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise,
    input  logic              fall,
    input  logic              hit,
    input  logic [IDX_W-1:0]  idx,
    input  logic              abort,
    input  logic [BYTE_W-1:0] load_src,
    output logic              tx_data,
    output logic              tx_oe,
    output logic              tx_drv_n,
    output logic              tx_load
);
    typedef struct packed {
        logic [BYTE_W-1:0] sh;
        logic              data;
        logic              oe;
        logic              drv_n;
        logic              load;
        logic              last;
    } tx_st_t;

    tx_st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.load = 1'b0;
        if (abort) begin
            s_d.oe    = 1'b0;
            s_d.drv_n = 1'b1;
            s_d.last  = 1'b0;
        end else if (rise) begin
            if (hit) begin
                if (idx == '0) begin
                    s_d.data = load_src[BYTE_W-1];
                    s_d.sh   = load_src << 1;
                    s_d.load = 1'b1;
                end else begin
                    s_d.data = s_q.sh[BYTE_W-1];
                    s_d.sh   = s_q.sh << 1;
                end
                s_d.oe    = 1'b1;
                s_d.drv_n = 1'b0;
                s_d.last  = (idx == IDX_W'(BYTE_W-1));
            end else begin
                s_d.oe    = 1'b0;
                s_d.drv_n = 1'b1;
                s_d.last  = 1'b0;
            end
        end else if (fall && s_q.last) begin
            s_d.drv_n = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.sh    <= '0;
            s_q.data  <= 1'b0;
            s_q.oe    <= 1'b0;
            s_q.drv_n <= 1'b1;
            s_q.load  <= 1'b0;
            s_q.last  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tx_data  = s_q.data;
    assign tx_oe    = s_q.oe;
    assign tx_drv_n = s_q.drv_n;
    assign tx_load  = s_q.load;

    // R7: the driver enable lies inside the output enable window
    a_r7_drv_inside_oe: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_drv_n |-> tx_oe);

    // R11: a byte is taken only at a slot start with both enables active
    a_r11_load_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |-> (tx_oe && !tx_drv_n));

    // R1: serial data moves only on a bit clock rise
    a_r1_data_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(s_q.data));

endmodule

// File: rtl/pcm_rx_path.sv
module pcm_rx_path #(
    parameter  int unsigned BYTE_W = 8,
    localparam int unsigned IDX_W  = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise,
    input  logic              fall,
    input  logic              hit,
    input  logic [IDX_W-1:0]  idx,
    input  logic              abort,
    input  logic              rx_data,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_valid
);
    typedef struct packed {
        logic [BYTE_W-1:0] sh;
        logic              pend;
        logic              last;
        logic [BYTE_W-1:0] byte_out;
        logic              valid;
    } rx_st_t;

    rx_st_t            s_d, s_q;
    logic [BYTE_W-1:0] shifted;

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        shifted   = {s_q.sh[BYTE_W-2:0], rx_data};
        if (abort) begin
            s_d.pend = 1'b0;
        end else if (rise) begin
            s_d.pend = hit;
            s_d.last = (idx == IDX_W'(BYTE_W-1));
        end else if (fall && s_q.pend) begin
            s_d.sh   = shifted;
            s_d.pend = 1'b0;
            if (s_q.last) begin
                s_d.byte_out = shifted;
                s_d.valid    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rx_byte  = s_q.byte_out;
    assign rx_valid = s_q.valid;

    // R2: a completed byte follows a bit clock falling edge
    a_r2_valid_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(fall));

    // R2: the valid strobe lasts a single clock
    a_r2_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port
    import pcm_slot_pkg::*;
#(
    parameter  int unsigned BYTE_W = 8,
    localparam int unsigned IDX_W  = $clog2(BYTE_W)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bclk,
    input  logic                  tx_fs,
    input  logic                  rx_fs,
    input  logic                  rx_data,
    input  logic                  delayed_mode,
    input  logic                  loopback,
    input  logic                  power_up,
    input  logic                  tx_cfg_wr,
    input  logic                  rx_cfg_wr,
    input  logic [PCM_SLOT_W:0]   cfg_wdata,
    input  logic [BYTE_W-1:0]     tx_byte,
    output logic                  tx_data,
    output logic                  tx_oe,
    output logic                  tx_drv_n,
    output logic                  tx_load,
    output logic [BYTE_W-1:0]     rx_byte,
    output logic                  rx_valid
);
    localparam int unsigned N_DIR = 2;

    logic             bclk_d, bclk_q;
    logic             bclk_rise, bclk_fall;
    logic [N_DIR-1:0] fs_v, wr_v, gate_v, hit_v, abort_v;
    logic [IDX_W-1:0] idx_v [N_DIR];
    slot_cfg_t        wcfg;
    logic [BYTE_W-1:0] load_src;

    always_comb begin
        bclk_d    = bclk;
        bclk_rise = bclk & ~bclk_q;
        bclk_fall = ~bclk & bclk_q;
        wcfg      = slot_cfg_t'(cfg_wdata);
        fs_v      = {rx_fs, tx_fs};
        wr_v      = {rx_cfg_wr, tx_cfg_wr};
        gate_v    = {1'b1, power_up};
        load_src  = loopback ? rx_byte : tx_byte;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_q <= 1'b0;
        end else begin
            bclk_q <= bclk_d;
        end
    end

    // index 0 serves transmit, index 1 serves receive
    for (genvar d = 0; d < N_DIR; d++) begin : g_dir
        pcm_slot_timer #(.BYTE_W(BYTE_W)) u_tmr (
            .clk     (clk),
            .rst_n   (rst_n),
            .rise    (bclk_rise),
            .fs      (fs_v[d]),
            .delayed (delayed_mode),
            .wr      (wr_v[d]),
            .gate    (gate_v[d]),
            .wcfg    (wcfg),
            .hit     (hit_v[d]),
            .idx     (idx_v[d]),
            .abort   (abort_v[d])
        );
    end

    pcm_tx_path #(.BYTE_W(BYTE_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (bclk_rise),
        .fall     (bclk_fall),
        .hit      (hit_v[0]),
        .idx      (idx_v[0]),
        .abort    (abort_v[0]),
        .load_src (load_src),
        .tx_data  (tx_data),
        .tx_oe    (tx_oe),
        .tx_drv_n (tx_drv_n),
        .tx_load  (tx_load)
    );

    pcm_rx_path #(.BYTE_W(BYTE_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (bclk_rise),
        .fall     (bclk_fall),
        .hit      (hit_v[1]),
        .idx      (idx_v[1]),
        .abort    (abort_v[1]),
        .rx_data  (rx_data),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid)
    );

    // R8: powered down means the transmit output is released
    a_r8_pwrdn_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        !power_up |=> !tx_oe);

    // R6: an assignment write silences the transmitter at once
    a_r6_wr_stops_tx: assert property (@(posedge clk) disable iff (!rst_n)
        tx_cfg_wr |=> !tx_oe);

endmodule

// File: tb/pcm_slot_port_bench.sv
module pcm_slot_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bclk = 1'b0, tx_fs = 1'b0, rx_fs = 1'b0, rx_data = 1'b0;
    logic       delayed_mode = 1'b0, loopback = 1'b0, power_up = 1'b0;
    logic       tx_cfg_wr = 1'b0, rx_cfg_wr = 1'b0;
    logic [6:0] cfg_wdata = '0;
    logic [7:0] tx_byte = '0;
    logic       tx_data, tx_oe, tx_drv_n, tx_load, rx_valid;
    logic [7:0] rx_byte;

    pcm_slot_port u_pcm_slot_port (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .tx_fs(tx_fs), .rx_fs(rx_fs),
        .rx_data(rx_data), .delayed_mode(delayed_mode), .loopback(loopback),
        .power_up(power_up), .tx_cfg_wr(tx_cfg_wr), .rx_cfg_wr(rx_cfg_wr),
        .cfg_wdata(cfg_wdata), .tx_byte(tx_byte), .tx_data(tx_data),
        .tx_oe(tx_oe), .tx_drv_n(tx_drv_n), .tx_load(tx_load),
        .rx_byte(rx_byte), .rx_valid(rx_valid)
    );

    always #2 clk = ~clk;

    int nvec = 0, nfail = 0, cyc = 0;
    bit done = 0;
    logic [31:0] rx_pat = 32'hC35A0FF0;

    // behavioural reference state
    int m_bclk = 0;
    int m_fsp[2], m_pos[2], m_arm[2], m_en[2], m_num[2];
    int t_sh = 0, t_last = 0, e_oe = 0, e_drv = 1, e_data = 0, e_load = 0;
    int r_sh = 0, r_pend = 0, r_last = 0, e_rxbyte = 0, e_valid = 0;

    // per-frame observations
    int f_cap, f_capn, f_first, f_drv, f_oe, f_load, f_rxv, f_rxb, after_wr_oe;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic m_timer(input int d, input int fs, input int wr, input int gate,
                           input int rise, output int hit, output int idx, output int ab);
        int lead, cur, armed;
        hit = 0; idx = 0;
        ab = (wr != 0 || gate == 0) ? 1 : 0;
        if (rise != 0) begin
            lead = (fs != 0 && m_fsp[d] == 0) ? 1 : 0;
            cur = m_pos[d];
            if (lead != 0) cur = delayed_mode ? -1 : 0;
            armed = (ab == 0 && (m_arm[d] == 2 || (lead != 0 && m_arm[d] == 1))) ? 1 : 0;
            if (cur >= 0 && armed != 0 && m_en[d] != 0 &&
                (delayed_mode || m_num[d] == 0) && (cur / 8) == m_num[d]) hit = 1;
            idx = (cur >= 0) ? cur % 8 : 0;
            if (lead != 0 && delayed_mode) m_pos[d] = 0;
            else if (cur < 0) m_pos[d] = -1;
            else m_pos[d] = (cur + 1 >= 512) ? -1 : cur + 1;
            m_fsp[d] = fs;
            if (ab == 0 && lead != 0 && m_arm[d] < 2) m_arm[d]++;
        end
        if (ab != 0) m_arm[d] = 0;
        if (wr != 0) begin
            m_en[d] = cfg_wdata[6];
            m_num[d] = int'(cfg_wdata[5:0]);
        end
    endtask

    task automatic model_step();
        int rise, fall, ht, it, at, hr, ir, ar;
        rise = (bclk && m_bclk == 0) ? 1 : 0;
        fall = (!bclk && m_bclk != 0) ? 1 : 0;
        m_bclk = bclk;
        m_timer(0, tx_fs, tx_cfg_wr, power_up, rise, ht, it, at);
        m_timer(1, rx_fs, rx_cfg_wr, 1, rise, hr, ir, ar);
        e_load = 0;
        if (at != 0) begin
            e_oe = 0; e_drv = 1; t_last = 0;
        end else if (rise != 0) begin
            if (ht != 0) begin
                if (it == 0) begin
                    t_sh = loopback ? e_rxbyte : int'(tx_byte);
                    e_load = 1;
                end
                e_data = (t_sh >> 7) & 1;
                t_sh = (t_sh << 1) & 255;
                e_oe = 1; e_drv = 0; t_last = (it == 7) ? 1 : 0;
            end else begin
                e_oe = 0; e_drv = 1; t_last = 0;
            end
        end else if (fall != 0 && t_last != 0) begin
            e_drv = 1;
        end
        e_valid = 0;
        if (ar != 0) r_pend = 0;
        else if (rise != 0) begin
            r_pend = hr; r_last = (ir == 7) ? 1 : 0;
        end else if (fall != 0 && r_pend != 0) begin
            r_sh = ((r_sh << 1) | int'(rx_data)) & 255;
            r_pend = 0;
            if (r_last != 0) begin
                e_rxbyte = r_sh; e_valid = 1;
            end
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        if (rst_n) begin
            model_step();
            chk(tx_oe == e_oe[0], "R1 tx_oe", tx_oe, e_oe);
            chk(tx_drv_n == e_drv[0], "R7 tx_drv_n", tx_drv_n, e_drv);
            chk(tx_load == e_load[0], "R11 tx_load", tx_load, e_load);
            chk(rx_valid == e_valid[0], "R2 rx_valid", rx_valid, e_valid);
            chk(rx_byte == e_rxbyte[7:0], "R2 rx_byte", rx_byte, e_rxbyte);
            if (e_oe != 0 && tx_oe) chk(tx_data == e_data[0], "R1 tx_data", tx_data, e_data);
            if (!tx_drv_n) f_drv++;
            if (tx_oe) f_oe++;
            if (tx_load) f_load++;
            if (rx_valid) begin f_rxv++; f_rxb = rx_byte; end
        end
    endtask

    task automatic wr_cfg(input int d, input logic [6:0] v);
        cfg_wdata = v;
        if (d == 0) tx_cfg_wr = 1'b1; else rx_cfg_wr = 1'b1;
        tick();
        tx_cfg_wr = 1'b0; rx_cfg_wr = 1'b0;
    endtask

    task automatic run_frame(input int nbits, input int fs_t, input int fs_r,
                             input int wr_bit, input logic [6:0] wr_val);
        f_cap = 0; f_capn = 0; f_first = -1; f_drv = 0; f_oe = 0;
        f_load = 0; f_rxv = 0; f_rxb = -1; after_wr_oe = -1;
        for (int b = 0; b < nbits; b++) begin
            if (b == wr_bit) begin
                wr_cfg(0, wr_val);
                after_wr_oe = tx_oe;
            end
            bclk = 1'b1;
            tx_fs = (b == fs_t);
            rx_fs = (b == fs_r);
            rx_data = rx_pat[31 - (b % 32)];
            tick();
            if (tx_oe) begin
                f_cap = ((f_cap << 1) | int'(tx_data)) & 255;
                f_capn++;
                if (f_first < 0) f_first = b;
            end
            tick();
            bclk = 1'b0;
            tick();
            tick();
        end
    endtask

    initial begin
        for (int d = 0; d < 2; d++) begin
            m_fsp[d] = 0; m_pos[d] = -1; m_arm[d] = 0; m_en[d] = 0; m_num[d] = 0;
        end
        tick(); tick(); tick();
        rst_n = 1'b1;
        tick();
        // R5 reset state: both directions disabled and idle
        chk(tx_oe == 1'b0, "R5 reset tx_oe", tx_oe, 0);
        chk(tx_drv_n == 1'b1, "R5 reset tx_drv_n", tx_drv_n, 1);
        chk(rx_valid == 1'b0, "R5 reset rx_valid", rx_valid, 0);

        // immediate mode, slot 0 both ways
        power_up = 1'b1; tx_byte = 8'hA5;
        wr_cfg(0, 7'h40); wr_cfg(1, 7'h40);
        run_frame(16, 0, 0, -1, 7'h00);
        chk(f_capn == 0, "R6 first frame after write silent", f_capn, 0);
        run_frame(16, 0, 0, -1, 7'h00);
        chk(f_capn == 8, "R1 bit count", f_capn, 8);
        chk(f_cap == 8'hA5, "R3 immediate slot byte", f_cap, 8'hA5);
        chk(f_first == 0, "R3 slot starts at sync bit", f_first, 0);
        chk(f_oe == 32, "R1 oe span", f_oe, 32);
        chk(f_drv == 30, "R7 driver span 7.5 bits", f_drv, 30);
        chk(f_load == 1, "R11 one load", f_load, 1);
        chk(f_rxv == 1 && f_rxb == 8'hC3, "R2 received byte", f_rxb, 8'hC3);

        // rewrite in mid-slot
        run_frame(16, 0, 0, 4, 7'h40);
        chk(after_wr_oe == 0, "R6 immediate stop", after_wr_oe, 0);
        chk(f_capn == 4, "R6 partial slot", f_capn, 4);
        run_frame(16, 0, 0, -1, 7'h00);
        chk(f_capn == 0, "R6 still waiting", f_capn, 0);
        run_frame(16, 0, 0, -1, 7'h00);
        chk(f_capn == 8 && f_cap == 8'hA5, "R6 active on second frame", f_cap, 8'hA5);

        // loopback
        loopback = 1'b1; tx_byte = 8'h11; rx_pat = 32'h96000000;
        run_frame(16, 0, 0, -1, 7'h00);
        chk(f_cap == 8'hC3, "R10 returns previous byte", f_cap, 8'hC3);
        run_frame(16, 0, 0, -1, 7'h00);
        chk(f_cap == 8'h96, "R10 returns received byte", f_cap, 8'h96);
        loopback = 1'b0; tx_byte = 8'h5E;

        // power control
        power_up = 1'b0;
        run_frame(16, 0, 0, -1, 7'h00);
        chk(f_oe == 0, "R8 powered down", f_oe, 0);
        power_up = 1'b1;
        run_frame(16, 0, 0, -1, 7'h00);
        chk(f_oe == 0, "R8 first sync after power-up", f_oe, 0);
        run_frame(16, 0, 0, -1, 7'h00);
        chk(f_capn == 8 && f_cap == 8'h5E, "R8 second sync after power-up", f_cap, 8'h5E);

        // disabled directions
        wr_cfg(0, 7'h00); wr_cfg(1, 7'h00);
        for (int k = 0; k < 3; k++) begin
            run_frame(16, 0, 0, -1, 7'h00);
            chk(f_oe == 0 && f_rxv == 0, "R5 disabled", f_oe + f_rxv, 0);
        end

        // immediate mode rejects a nonzero slot
        wr_cfg(0, 7'h41);
        for (int k = 0; k < 3; k++) begin
            run_frame(16, 0, 0, -1, 7'h00);
            chk(f_oe == 0, "R3 nonzero slot ignored", f_oe, 0);
        end

        // offset mode with skewed frames
        delayed_mode = 1'b1; tx_byte = 8'h3C; rx_pat = 32'h12345678;
        wr_cfg(0, 7'h42); wr_cfg(1, 7'h41);
        run_frame(32, 3, 10, -1, 7'h00);
        run_frame(32, 3, 10, -1, 7'h00);
        chk(f_first == 20, "R4 slot 2 position", f_first, 20);
        chk(f_cap == 8'h3C, "R4 slot 2 byte", f_cap, 8'h3C);
        chk(f_rxv == 1 && f_rxb == int'((rx_pat >> 5) & 32'hFF), "R9 skewed receive slot",
            f_rxb, int'((rx_pat >> 5) & 32'hFF));

        // slot beyond frame end
        wr_cfg(0, 7'h45);
        for (int k = 0; k < 3; k++) begin
            run_frame(32, 3, 10, -1, 7'h00);
            chk(f_oe == 0, "R4 slot past frame end", f_oe, 0);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

endmodule